// File: doc/BRIEF.md
# Bus Arbitration Loss Detector

This block watches a two-wire serial bus while the local controller drives bytes onto it. On every rising edge of the clock line it compares the bit the controller meant to send with the level it reads back on the data line. A frame is nine clock pulses long: eight data bits and one acknowledge bit. When another driver pulls the data line low while this side has released it, the local side has lost arbitration. The block raises a sticky status flag and can take its own data driver off the bus.

A mode input picks when the flag is updated. In per-bit mode the flag follows each comparison. In per-frame mode every loss inside the frame is remembered, and the flag is raised when the ninth clock pulse falls. A separate enable lets the loss event also raise an output-disable signal, which puts the data driver into high impedance.

The bus lines arrive already synchronized to the system clock. The block finds clock-line edges itself, and also start and stop conditions, from the registered line levels. Shifting, acknowledge generation and producing start or stop conditions are handled elsewhere.

Top module: `i2c_arb_loss_det`

## Requirements
- R1: After reset, `arb_lost` and `sda_off` are both 0.
- R2: A bit counts as lost only when `tx_bit`=1 (line released) and `sda_in`=0 at an SCL rising edge. Driving 0 while reading 1 never counts.
- R3: In per-bit mode (`mode_byte`=0), each checked SCL rising edge updates `arb_lost`.
  - The new value is visible one clock after the rising edge is sampled.
  - The flag becomes 1 on a lost bit and 0 on a matching bit.
  - An unchecked edge leaves it unchanged.
- R4: In per-frame mode (`mode_byte`=1), `arb_lost` can rise only on the SCL falling edge of bit 9 of a frame, and only if a lost bit was seen in that frame.
- R5: In per-frame mode, only `clr_stb` clears `arb_lost`; matching bits and new frames leave it at 1.
- R6: A `clr_stb` pulse clears `arb_lost` and `sda_off`. If a set event occurs in the same cycle, the set wins.
- R7: When `stop_en`=1, `sda_off` goes to 1 in the same cycle as `arb_lost`. When `stop_en`=0, `sda_off` never rises.
- R8: `sda_off` returns to 0 when `arb_lost` is cleared, or on a stop condition (SDA rising while SCL is high). A stop condition leaves `arb_lost` unchanged.
- R9: A start condition (SDA falling while SCL is high) restarts bit numbering, so the SCL pulse that follows is bit 1 of a new frame.
- R10: The per-frame loss memory is emptied at the start of every frame. A loss in an abandoned or earlier frame never sets the flag in a later frame.
- R11: Bit 9 (acknowledge) is compared only when `xmit_mode`=1. Bits 1 to 8 are always compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized clock-line level |
| sda_in | input | 1 | Synchronized data-line level |
| tx_bit | input | 1 | Bit the local side is driving (1 = released) |
| xmit_mode | input | 1 | 1 = local side transmits the frame, so the acknowledge bit is compared |
| mode_byte | input | 1 | 0 = per-bit flag update, 1 = per-frame flag update |
| stop_en | input | 1 | 1 = a loss event also raises `sda_off` |
| clr_stb | input | 1 | One-cycle software clear of the flag |
| arb_lost | output | 1 | Arbitration-lost status flag |
| sda_off | output | 1 | 1 = data driver must be high impedance |

## Verification
Bus-line changes are first seen through the one-stage edge registers. In the cycle an edge is seen, the flag and disable registers load, so both outputs are due one clock after the input change that forms the edge.

The bench drives every input on a falling clock edge and then waits exactly one falling edge before sampling. Each check therefore lands in the cycle right after the deciding edge has been registered.

Per-frame timing is pinned down by sampling after the ninth rising edge, where the flag must still be 0. The next sample, after the ninth falling edge, must show the flag at 1.

// File: rtl/arbdet_pkg.sv
// Shared constants and types for the arbitration loss detector.
// Assumes a frame of eight data bits followed by one acknowledge bit.
package arbdet_pkg;
    localparam int FRAME_BITS = 9;
    localparam int POS_W      = $clog2(FRAME_BITS + 1);
    typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/arbdet_line_events.sv
// Finds clock-line edges and start/stop conditions from registered levels.
// Assumes scl_in/sda_in are already synchronized to clk; idle bus is high.
module arbdet_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Decode edges and bus conditions from old and new levels.
    always_comb begin
        scl_rise = scl_in & ~scl_q;
        scl_fall = ~scl_in & scl_q;
        start_ev = scl_in & scl_q & sda_q & ~sda_in;
        stop_ev  = scl_in & scl_q & ~sda_q & sda_in;
    end
endmodule

// File: rtl/arbdet_bit_pos.sv
// Counts SCL pulses within a frame: 1..FRAME_BITS, then wraps to 1.
// Assumes a start condition never coincides with an SCL rising edge.
module arbdet_bit_pos #(
    parameter int FRAME_BITS = arbdet_pkg::FRAME_BITS,
    parameter int POS_W      = arbdet_pkg::POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             start_ev,
    output logic [POS_W-1:0] cur_bit,
    output logic             last_bit
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS);
    localparam logic [POS_W-1:0] ONE  = POS_W'(1);

    logic [POS_W-1:0] pos_q;

    // Number of the bit sampled at the next rising edge.
    always_comb begin
        if (pos_q == '0 || pos_q == LAST) cur_bit = ONE;
        else                              cur_bit = pos_q + ONE;
        last_bit = (pos_q == LAST);
    end

    // Advance on each rising edge; restart on a start condition.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos_q <= '0;
        else if (start_ev) pos_q <= '0;
        else if (scl_rise) pos_q <= cur_bit;
    end
endmodule

// File: rtl/arbdet_compare.sv
// Compares the driven bit with the line at each SCL rise and remembers losses per frame.
// Assumes tx_bit=1 means the line is released by the local driver.
module arbdet_compare #(
    parameter int FRAME_BITS = arbdet_pkg::FRAME_BITS,
    parameter int POS_W      = arbdet_pkg::POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             start_ev,
    input  logic [POS_W-1:0] cur_bit,
    input  logic             xmit_mode,
    input  logic             tx_bit,
    input  logic             sda_in,
    output logic             checked,
    output logic             miss_now,
    output logic             miss_seen
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS);
    localparam logic [POS_W-1:0] ONE  = POS_W'(1);

    // Decide whether this edge is checked and whether it shows a loss.
    always_comb begin
        checked  = scl_rise & ((cur_bit != LAST) | xmit_mode);
        miss_now = checked & tx_bit & ~sda_in;
    end

    // Loss memory: fresh at bit 1 and at start, sticky within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                          miss_seen <= 1'b0;
        else if (start_ev)                   miss_seen <= 1'b0;
        else if (scl_rise && cur_bit == ONE) miss_seen <= miss_now;
        else if (miss_now)                   miss_seen <= 1'b1;
    end
endmodule

// File: rtl/i2c_arb_loss_det.sv
// Arbitration loss detector: keeps the loss flag and the data-driver disable.
// Assumes synchronized inputs and a one-cycle clr_stb pulse from software.
module i2c_arb_loss_det #(
    parameter int FRAME_BITS = arbdet_pkg::FRAME_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic tx_bit,
    input  logic xmit_mode,
    input  logic mode_byte,
    input  logic stop_en,
    input  logic clr_stb,
    output logic arb_lost,
    output logic sda_off
);
    localparam int POS_W = $clog2(FRAME_BITS + 1);

    logic             scl_rise, scl_fall, start_ev, stop_ev;
    logic [POS_W-1:0] cur_bit;
    logic             last_bit;
    logic             checked, miss_now, miss_seen;
    logic             set_ev, clr_ev;

    arbdet_line_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    arbdet_bit_pos #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .start_ev(start_ev),
        .cur_bit(cur_bit), .last_bit(last_bit)
    );

    arbdet_compare #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .start_ev(start_ev),
        .cur_bit(cur_bit), .xmit_mode(xmit_mode), .tx_bit(tx_bit),
        .sda_in(sda_in), .checked(checked), .miss_now(miss_now),
        .miss_seen(miss_seen)
    );

    // Set and clear requests for the flag, per update mode.
    always_comb begin
        if (mode_byte) set_ev = scl_fall & last_bit & miss_seen;
        else           set_ev = miss_now;
        clr_ev = (clr_stb | (~mode_byte & checked & ~miss_now)) & ~set_ev;
    end

    // Status flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)      arb_lost <= 1'b0;
        else if (set_ev) arb_lost <= 1'b1;
        else if (clr_ev) arb_lost <= 1'b0;
    end

    // Driver disable: rises with the flag when enabled, drops on clear or stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sda_off <= 1'b0;
        else if (set_ev && stop_en) sda_off <= 1'b1;
        else if (clr_ev || stop_ev) sda_off <= 1'b0;
    end
endmodule

// File: rtl/arbdet_checker.sv
// Temporal checks for i2c_arb_loss_det, attached by bind.
// Assumes access to the top's internal SCL edge strobes.
module arbdet_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_bit,
    input logic mode_byte,
    input logic stop_en,
    input logic clr_stb,
    input logic scl_rise,
    input logic scl_fall,
    input logic arb_lost,
    input logic sda_off
);
    AST_OFF_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sda_off |-> arb_lost); // R8
    AST_OFF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_off) |-> $past(stop_en)); // R7
    AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_en && !sda_off) |=> !sda_off); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !scl_rise && !scl_fall) |=> (!arb_lost && !sda_off)); // R6
    AST_BYTE_SET_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte && !scl_fall) |=> !$rose(arb_lost)); // R4
    AST_BYTE_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte && !clr_stb && arb_lost) |=> arb_lost); // R5
    AST_DRIVE_LOW_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_byte && scl_rise && !tx_bit && !arb_lost) |=> !arb_lost); // R2
endmodule

bind i2c_arb_loss_det arbdet_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .mode_byte(mode_byte),
    .stop_en(stop_en), .clr_stb(clr_stb), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .arb_lost(arb_lost), .sda_off(sda_off)
);

// File: tb/i2c_arb_loss_det_test.sv
`timescale 1ns/1ps
module i2c_arb_loss_det_test;
    logic clk = 1'b0;
    logic rst_n;
    logic scl_in, sda_in, tx_bit, xmit_mode, mode_byte, stop_en, clr_stb;
    logic arb_lost, sda_off;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    i2c_arb_loss_det uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .tx_bit(tx_bit), .xmit_mode(xmit_mode), .mode_byte(mode_byte),
        .stop_en(stop_en), .clr_stb(clr_stb), .arb_lost(arb_lost),
        .sda_off(sda_off)
    );

    // {mode_byte, stop_en, xmit, tx[8:0], rx[8:0], exp_flag, exp_off}; tx[8] is bit 1
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {3'b011, 9'h1FF, 9'h1FF, 2'b00},   // R3 all match
        {3'b011, 9'h1FF, 9'h0FF, 2'b00},   // R3 loss then match clears
        {3'b111, 9'h1FF, 9'h0FF, 2'b11},   // R4 loss bit 1 remembered
        {3'b101, 9'h000, 9'h1FF, 2'b00},   // R2 drive 0 read 1 ignored
        {3'b011, 9'h1FF, 9'h1FE, 2'b11},   // R11 ack loss counted when xmit
        {3'b010, 9'h1FF, 9'h1FE, 2'b00},   // R11 ack not compared when receiving
        {3'b110, 9'h1FF, 9'h1FE, 2'b00},   // R11 per-frame, ack ignored
        {3'b101, 9'h1FF, 9'h1EF, 2'b10},   // R7 no disable without enable
        {3'b001, 9'h1AA, 9'h0AA, 2'b00},   // R3 last checked bit matches
        {3'b111, 9'h0FF, 9'h0FE, 2'b11}    // R4 ack loss in per-frame mode
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    task automatic drv(input logic s, input logic d, input logic t, input logic c);
        scl_in = s; sda_in = d; tx_bit = t; clr_stb = c;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic t, input logic d);
        drv(0, d, t, 0);
        drv(1, d, t, 0);
        drv(0, d, t, 0);
    endtask

    task automatic start_cond();
        drv(0, 1, 0, 0);
        drv(1, 1, 0, 0);
        drv(1, 0, 0, 0);
        drv(0, 0, 0, 0);
    endtask

    task automatic stop_cond();
        drv(0, 0, 0, 0);
        drv(1, 0, 0, 0);
        drv(1, 1, 0, 0);
    endtask

    task automatic clear_pulse();
        drv(scl_in, sda_in, tx_bit, 1);
        drv(scl_in, sda_in, tx_bit, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; scl_in = 1; sda_in = 1; tx_bit = 0; clr_stb = 0;
        xmit_mode = 1; mode_byte = 0; stop_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 flag", arb_lost, 1'b0);
        chk("R1 off", sda_off, 1'b0);

        for (int v = 0; v < NV; v++) begin
            mode_byte = VEC[v][22]; stop_en = VEC[v][21]; xmit_mode = VEC[v][20];
            clear_pulse();
            start_cond();
            for (int b = 8; b >= 0; b--) send_bit(VEC[v][11 + b], VEC[v][2 + b]);
            chk($sformatf("R3/R4 vec%0d flag", v), arb_lost, VEC[v][1]);
            chk($sformatf("R7 vec%0d off", v), sda_off, VEC[v][0]);
            stop_cond();
        end

        // R3 R7: per-bit set with disable in the same cycle, then match clears (R8)
        mode_byte = 0; stop_en = 1; xmit_mode = 1;
        clear_pulse(); start_cond();
        drv(0, 0, 1, 0); drv(1, 0, 1, 0);
        chk("R3 set flag", arb_lost, 1'b1);
        chk("R7 same cycle off", sda_off, 1'b1);
        drv(0, 0, 1, 0);
        drv(0, 1, 1, 0); drv(1, 1, 1, 0);
        chk("R3 match clears", arb_lost, 1'b0);
        chk("R8 off follows clear", sda_off, 1'b0);
        drv(0, 1, 1, 0);
        // R6: clear strobe in the same cycle as a set loses
        drv(0, 0, 1, 0); drv(1, 0, 1, 1);
        chk("R6 set beats clear", arb_lost, 1'b1);
        drv(0, 0, 1, 0);
        stop_cond();

        // R4: per-frame flag waits for the 9th falling edge
        mode_byte = 1; stop_en = 1; xmit_mode = 1;
        clear_pulse(); start_cond();
        send_bit(1, 0);
        for (int b = 0; b < 7; b++) send_bit(1, 1);
        drv(0, 1, 1, 0); drv(1, 1, 1, 0);
        chk("R4 not at 9th rise", arb_lost, 1'b0);
        drv(0, 1, 1, 0);
        chk("R4 set at 9th fall", arb_lost, 1'b1);
        chk("R7 off with frame flag", sda_off, 1'b1);

        // R5: matching frame keeps flag; R8 stop drops off only; R6 clear
        start_cond();
        for (int b = 0; b < 9; b++) send_bit(1, 1);
        chk("R5 no hw clear", arb_lost, 1'b1);
        stop_cond();
        chk("R8 stop keeps flag", arb_lost, 1'b1);
        chk("R8 stop releases", sda_off, 1'b0);
        clear_pulse();
        chk("R6 clear flag", arb_lost, 1'b0);

        // R10: loss in an abandoned frame is forgotten after restart
        stop_en = 0;
        start_cond();
        send_bit(1, 1); send_bit(1, 0); send_bit(1, 1); send_bit(1, 1);
        start_cond();
        for (int b = 0; b < 9; b++) send_bit(1, 1);
        chk("R10 memory cleared", arb_lost, 1'b0);

        // R9: restart mid-frame renumbers bits
        start_cond();
        for (int b = 0; b < 4; b++) send_bit(1, 1);
        start_cond();
        send_bit(1, 0);
        for (int b = 0; b < 7; b++) send_bit(1, 1);
        chk("R9 no set at 8th bit", arb_lost, 1'b0);
        send_bit(1, 1);
        chk("R9 set at new 9th bit", arb_lost, 1'b1);
        chk("R7 off stays low", sda_off, 1'b0);
        stop_cond();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule